// File: doc/BRIEF.md
# Compare-Match Tick Timer

This block is a per-core cycle timer with a compare unit. A 32-bit counter advances on every clock while a control word selects a running mode. The control word also holds a 28-bit period, an interrupt-enable flag and an interrupt-pending flag. When the low 28 bits of the counter equal the period, the timer flags a hit. What follows the hit depends on the mode: the counter returns to zero, freezes, or carries on through the full 32-bit range.

Carrying on through a hit is the mode that lets the counter serve as a monotonic time base while the same hardware delivers one-shot events. Software arms the next event by writing a period relative to the current count. It acknowledges the event by rewriting the control word with only the free-running mode selected.

Software reaches the three words through a small register port with an address, a write strobe, write data and registered read data. A read-only capability word reports that the timer is present. A single level output carries the interrupt.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset the counter word and the control word read as zero and `irq` is low.
- R2: The counter adds one per clock when the mode field (control bits [31:30]) is nonzero. It holds its value when the mode field is 00 (off).
- R3: A write to address 0 loads the counter with the write data. This load takes precedence over any increment, clear or hold in the same cycle.
- R4: A hit occurs when the mode is not off and counter bits [27:0] equal the period in control bits [27:0]. Counter bits [31:28] play no part. A hit sets the pending flag (control bit 28) on the next edge, whether or not the interrupt is enabled.
- R5: `irq` is high exactly when the pending flag and the enable flag (control bit 29) are both set.
- R6: In mode 11 (free-run) the counter keeps incrementing through a hit and wraps from 0xFFFFFFFF to 0.
- R7: In mode 01 (restart) the counter becomes zero on the edge after a hit.
- R8: In mode 10 (stop) the counter stays at the hit value for as long as the mode and period are unchanged.
- R9: A control write (address 1) takes bits [31:29] and [27:0] from the write data. Writing 0 to bit 28 clears the pending flag, and writing 1 to it leaves the flag unchanged. A hit in the same cycle as a clearing write leaves the flag set. Writing 0xC0000000 acknowledges the interrupt: it clears pending and enable while the counter keeps running.
- R10: Address 2 reads 0x00000001, where bit 0 means the timer is present. Writes to address 2 have no effect on any register.
- R11: Read data is registered. `rdata` shows, one clock after `addr` is presented, the addressed word as it stood before that edge. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address: 0 counter, 1 control, 2 capability |
| we | input | 1 | Write strobe for the addressed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt level |

## Verification
The bench places the counter's low 28 bits at the period while the upper bits are nonzero. A comparator that used the full width would then never raise the interrupt. It also times the interrupt edge exactly: a hit logged one cycle early or late moves `irq` off its expected edge. A counter write is made while the counter runs, and the counter is crossed over its 32-bit wrap in free-run mode. An increment that beat the load, or a counter that saturated, would give the wrong read value. The bench clears the pending flag on the same edge that the stop mode re-hits, to check that the hardware set wins. It also checks that a software 1 in the pending bit does not raise an interrupt, and that a write to the capability word leaves it and the counter unchanged.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    TM_OFF     = 2'b00,
    TM_RESTART = 2'b01,
    TM_STOP    = 2'b10,
    TM_FREE    = 2'b11
  } tm_mode_e;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_CAPS  = 2'd2;

  localparam int CAPS_PRESENT_BIT = 0;

endpackage

// File: rtl/tt_compare.sv
module tt_compare
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [PER_W-1:0] period,
  input  tm_mode_e         mode,
  output logic             hit
);

  logic [PER_W-1:0] cnt_low;

  assign cnt_low = cnt[PER_W-1:0];

  // upper counter bits deliberately excluded from the comparison
  always_comb begin
    hit = (mode != TM_OFF) && (cnt_low == period);
  end

endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  tm_mode_e         mode,
  input  logic             hit,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_inc = cnt_q + CNT_ONE;

  always_comb begin
    cnt_nxt = cnt_q;
    if (load) begin
      cnt_nxt = load_val;
    end else begin
      unique case (mode)
        TM_OFF:     cnt_nxt = cnt_q;
        TM_RESTART: cnt_nxt = hit ? CNT_ZERO : cnt_inc;
        TM_STOP:    cnt_nxt = hit ? cnt_q : cnt_inc;
        TM_FREE:    cnt_nxt = cnt_inc;
        default:    cnt_nxt = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= CNT_ZERO;
    else     cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tick_timer_pkg::*;
#(
  parameter int PER_W = 28
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [PER_W+3:0]     wdata,
  input  logic                 hit,
  output logic [PER_W-1:0]     period_q,
  output logic                 pend_q,
  output logic                 en_q,
  output tm_mode_e             mode_q,
  output logic                 irq_q
);

  localparam int PEND_BIT = PER_W;
  localparam int EN_BIT   = PER_W + 1;
  localparam int MODE_LO  = PER_W + 2;

  logic     pend_nxt;
  logic     en_nxt;
  logic     clr_req;

  assign clr_req = wr && !wdata[PEND_BIT];

  always_comb begin
    // a hardware hit outranks a software clear in the same cycle
    pend_nxt = hit || (pend_q && !clr_req);
    en_nxt   = wr ? wdata[EN_BIT] : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      pend_q   <= 1'b0;
      en_q     <= 1'b0;
      mode_q   <= TM_OFF;
      irq_q    <= 1'b0;
    end else begin
      if (wr) begin
        period_q <= wdata[PER_W-1:0];
        mode_q   <= tm_mode_e'(wdata[MODE_LO+1:MODE_LO]);
      end
      pend_q <= pend_nxt;
      en_q   <= en_nxt;
      irq_q  <= pend_nxt && en_nxt;
    end
  end

endmodule

// File: rtl/tt_readback.sv
module tt_readback
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] cnt_word,
  input  logic [DATA_W-1:0] ctrl_word,
  output logic [DATA_W-1:0] rdata_q
);

  localparam logic [DATA_W-1:0] CAPS_WORD = DATA_W'(1) << CAPS_PRESENT_BIT;

  logic [DATA_W-1:0] sel;

  always_comb begin
    unique case (addr)
      ADDR_COUNT: sel = cnt_word;
      ADDR_CTRL:  sel = ctrl_word;
      ADDR_CAPS:  sel = CAPS_WORD;
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= sel;
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int PER_W = 28,
  parameter int CNT_W = PER_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);

  logic             cnt_load;
  logic             ctrl_wr;
  logic [CNT_W-1:0] cnt_q;
  logic [PER_W-1:0] period_q;
  logic             pend_q;
  logic             en_q;
  tm_mode_e         mode_q;
  logic             hit;
  logic [CNT_W-1:0] ctrl_word;

  assign cnt_load  = we && (addr == ADDR_COUNT);
  assign ctrl_wr   = we && (addr == ADDR_CTRL);
  assign ctrl_word = {mode_q, en_q, pend_q, period_q};

  tt_compare #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cmp (
    .cnt    (cnt_q),
    .period (period_q),
    .mode   (mode_q),
    .hit    (hit)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (wdata),
    .mode     (mode_q),
    .hit      (hit),
    .cnt_q    (cnt_q)
  );

  tt_ctrl #(.PER_W(PER_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (ctrl_wr),
    .wdata    (wdata),
    .hit      (hit),
    .period_q (period_q),
    .pend_q   (pend_q),
    .en_q     (en_q),
    .mode_q   (mode_q),
    .irq_q    (irq)
  );

  tt_readback #(.DATA_W(CNT_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .cnt_word  (cnt_q),
    .ctrl_word (ctrl_word),
    .rdata_q   (rdata)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int PER_W = 28,
  parameter int CNT_W = PER_W + 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       addr,
  input logic             we,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] rdata,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             pend,
  input logic             en,
  input tm_mode_e         mode,
  input logic             hit
);

  logic cnt_wr;
  assign cnt_wr = we && (addr == ADDR_COUNT);

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (cnt == '0) && !irq && (mode == TM_OFF));

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (rst)
    irq == (pend && en));

  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cnt_wr) && $past(mode) == TM_FREE)
      |-> cnt == $past(cnt) + CNT_W'(1));

  assert_hold_off_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cnt_wr) && $past(mode) == TM_OFF) |-> $stable(cnt));

  assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt_wr)) |-> cnt == $past(wdata));

  assert_hit_pends_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hit)) |-> pend);

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hit) && !$past(cnt_wr) && $past(mode) == TM_RESTART)
      |-> cnt == '0);

  assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hit) && !$past(cnt_wr) && $past(mode) == TM_STOP)
      |-> $stable(cnt));

  assert_caps_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr) == ADDR_CAPS) |-> rdata == CNT_W'(1));

endmodule

bind tick_timer tick_timer_chk #(.PER_W(PER_W), .CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .addr  (addr),
  .we    (we),
  .wdata (wdata),
  .rdata (rdata),
  .irq   (irq),
  .cnt   (cnt_q),
  .pend  (pend_q),
  .en    (en_q),
  .mode  (mode_q),
  .hit   (hit)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tick_timer uut (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr),
    .we    (we),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  // entry: {is_write, addr, data, expected read}
  localparam int NV = 12;
  localparam logic [66:0] VEC [NV] = '{
    {1'b0, 2'd0, 32'h0,        32'h0},        // R1 counter zero
    {1'b0, 2'd1, 32'h0,        32'h0},        // R1 control zero
    {1'b0, 2'd2, 32'h0,        32'h1},        // R10 present bit
    {1'b1, 2'd0, 32'h7,        32'h0},        // R3 load
    {1'b0, 2'd0, 32'h0,        32'h7},        // R2 off mode holds
    {1'b1, 2'd1, 32'h30ABCDEF, 32'h0},        // R9 pending 1 ignored
    {1'b0, 2'd1, 32'h0,        32'h20ABCDEF}, // R9 readback
    {1'b1, 2'd2, 32'hFFFFFFFF, 32'h0},        // R10 write ignored
    {1'b0, 2'd2, 32'h0,        32'h1},        // R10
    {1'b0, 2'd0, 32'h0,        32'h7},        // R10 counter untouched
    {1'b0, 2'd3, 32'h0,        32'h0},        // R11 unmapped
    {1'b1, 2'd1, 32'h0,        32'h0}         // clear control
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] a0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][66]) wr(VEC[i][65:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][65:64], v);
        check($sformatf("R11 vec%0d", i), v, VEC[i][31:0]);
      end
    end

    // R7 restart: period 5, enabled
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h6000_0005);
    repeat (5) @(negedge clk);
    check("R5 irq before hit", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R4 irq at hit", {31'b0, irq}, 32'h1);
    rd(2'd0, v);
    check("R7 cleared after hit", v, 32'h0);

    // R8 stop: period 5, not enabled
    wr(2'd1, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h8000_0005);
    repeat (20) @(negedge clk);
    rd(2'd0, v);
    check("R8 held at hit value", v, 32'h5);
    rd(2'd1, v);
    check("R4 pending without enable", v, 32'h9000_0005);
    check("R5 irq gated by enable", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h0);
    rd(2'd1, v);
    check("R9 hit beats clear", v, 32'h1000_0000);
    wr(2'd1, 32'h0);
    rd(2'd1, v);
    check("R9 clear", v, 32'h0);

    // R4 upper counter bits ignored, free-run
    wr(2'd0, 32'h5000_0003);
    wr(2'd1, 32'hE000_0005);
    repeat (2) @(negedge clk);
    check("R4 no early irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R4 low-bit match irq", {31'b0, irq}, 32'h1);
    rd(2'd0, v);
    check("R6 runs through hit", v, 32'h5000_0006);

    // R3 load while running, R6 wrap
    wr(2'd0, 32'hFFFF_FFFE);
    rd(2'd0, v);
    check("R3 load beats increment", v, 32'hFFFF_FFFE);
    rd(2'd0, v);
    check("R6 pre-wrap", v, 32'hFFFF_FFFF);
    rd(2'd0, v);
    check("R6 wrap to zero", v, 32'h0);

    // R9 acknowledge
    wr(2'd1, 32'hC000_0000);
    check("R9 ack drops irq", {31'b0, irq}, 32'h0);
    rd(2'd1, v);
    check("R9 ack control", v, 32'hC000_0000);
    rd(2'd0, a0);
    repeat (3) @(negedge clk);
    rd(2'd0, v);
    check("R2 keeps counting after ack", v - a0, 32'h4);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule